// File: doc/BRIEF.md
# Paired-Source Four-Level Interrupt Controller

This block gathers requests from twelve interrupt sources and presents one of them at a time to a processor as a request line plus a 4-bit source number. Every source keeps a pending flag. The on-chip peripherals set a flag with a one-cycle pulse. Two sources (numbers 0 and 1) are driven from external pins instead. Each of these pins can be configured as falling-edge sensitive or as level sensitive. Software can write any flag through a small write port, so it can raise or cancel an interrupt exactly as the hardware would.

The sources are grouped into six fixed pairs, and each pair has one of four priority levels. Each level is built from two configuration vectors: a high bit and a low bit at the pair's own position. The controller records which levels are being serviced. A new request reaches the processor only when its level is strictly above the highest level in service, so nesting only goes upward. An acknowledge pulse takes the request, marks its level as in service and clears its flag. A return pulse closes the most recent (highest) level.

Top module: `pair_prio_irq_ctrl`

## Requirements
- R1: A one-cycle pulse on `int_set[k]` sets the flag of source k+2 (shown on `pend`) at the next clock edge. When the source is acknowledged, its flag clears (except for a level-sensitive pin source). A hardware set in the same cycle as the clear wins.
- R2: When `sw_wr` is high, the flag selected by `sw_idx` takes the value `sw_val` at the next edge. This overrides any hardware set or clear in that cycle.
- R3: With `ext_level[e]`=0, a high-to-low change on `ext_pin[e]` sets the flag of source e. This happens at the third clock edge after the pin changes (two synchroniser stages, then the flag). A pin held low does not set the flag again.
- R4: With `ext_level[e]`=1, the flag of source e equals the inverted synchronised pin, with the same three-edge latency. Software writes to that flag have no effect.
- R5: Pair p holds sources 2p and 2p+1. Its level is {`lvl_hi[p]`, `lvl_lo[p]`}, where 3 is the highest level and 0 the lowest.
- R6: A flag can request only when its bit in `src_en` is 1 and `glob_en` is 1.
- R7: Among the eligible flags, the highest level wins. On a tie, the lower source number wins (the first source of a pair beats the second, and a lower pair beats a higher pair).
- R8: A flag is eligible only if its level is strictly greater than the highest level set in `in_service`, or if `in_service` is zero. While level 3 is in service, no request is raised.
- R9: `irq` rises one edge after an eligible flag is seen while `irq` is low. `irq` and `irq_idx` then hold until `ack`. An `ack` while `irq` is low is ignored.
- R10: `ack` while `irq` is high sets the `in_service` bit of that source's level and drops `irq` at the same edge. The next request may rise one edge later. Reset clears all flags, `in_service` and `irq`.
- R11: A `reti` pulse clears the highest set bit of `in_service`. When `reti` and `ack` arrive in the same cycle, the clear happens first, then the set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| int_set | input | 10 | Set pulses for sources 2..11 (bit k is source k+2) |
| ext_pin | input | 2 | Asynchronous pins for sources 0 and 1, idle high |
| ext_level | input | 2 | 1 = level-sensitive pin, 0 = falling edge |
| sw_wr | input | 1 | Software flag write strobe |
| sw_idx | input | 4 | Source number written |
| sw_val | input | 1 | Value written to the flag |
| src_en | input | 12 | Per-source enable |
| glob_en | input | 1 | Global enable |
| lvl_hi | input | 6 | Level high bit, one per pair |
| lvl_lo | input | 6 | Level low bit, one per pair |
| ack | input | 1 | One-cycle acknowledge from the processor |
| reti | input | 1 | One-cycle return-from-handler pulse |
| irq | output | 1 | Interrupt request |
| irq_idx | output | 4 | Source number of the request |
| pend | output | 12 | Pending flags |
| in_service | output | 4 | Levels being serviced, one bit per level |

## Verification
A wrong in-service bitmap shows up at the ports in one of two ways. A request that should preempt never rises, or one rises that should wait. This appears one edge after the flag or after the `reti` that changes the threshold. A corrupted flag or pin synchroniser appears on `pend` at the edge the requirements name, and on `irq_idx` one edge later. So every vector and directed case samples exactly at those edges. Level and tie-break ordering is exercised with competing pairs whose high and low bits are swapped against each other, which exposes a swapped bit order or a reversed scan.

// File: rtl/pic_pkg.sv
package pic_pkg;
    parameter int NUM_SRC     = 12;
    parameter int NUM_PAIR    = NUM_SRC / 2;
    parameter int NUM_EXT     = 2;
    parameter int NUM_LVL     = 4;
    parameter int LVL_W       = $clog2(NUM_LVL);
    parameter int IDX_W       = $clog2(NUM_SRC);
    parameter int SYNC_STAGES = 2;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [IDX_W-1:0] idx_t;

    typedef struct packed {
        logic [NUM_SRC-1:0] flag;
        logic [NUM_LVL-1:0] isv;
        logic               irq;
        idx_t               idx;
    } pic_state_t;
endpackage

// File: rtl/pic_pin_cond.sv
module pic_pin_cond
    import pic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall,
    output logic low
);
    localparam int DEPTH = SYNC_STAGES + 1;

    logic [DEPTH-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[DEPTH-2:0], pin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign low  = !sh_q[SYNC_STAGES-1];
    assign fall = !sh_q[SYNC_STAGES-1] && sh_q[SYNC_STAGES];
endmodule

// File: rtl/pic_prio_sel.sv
module pic_prio_sel
    import pic_pkg::*;
(
    input  logic [NUM_SRC-1:0]  cand,
    input  logic [NUM_PAIR-1:0] lvl_hi,
    input  logic [NUM_PAIR-1:0] lvl_lo,
    input  logic [NUM_LVL-1:0]  isv,
    output logic                found,
    output idx_t                win_idx,
    output lvl_t                win_lvl
);
    logic top_any;
    lvl_t top_lvl;
    lvl_t src_lvl;

    always_comb begin
        top_any = |isv;
        top_lvl = '0;
        for (int l = 0; l < NUM_LVL; l++) begin
            if (isv[l]) top_lvl = lvl_t'(l);
        end
        found   = 1'b0;
        win_idx = '0;
        win_lvl = '0;
        src_lvl = '0;
        // downward scan with >= lets the lower index win ties
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            src_lvl = {lvl_hi[i/2], lvl_lo[i/2]};
            if (cand[i] && (!top_any || src_lvl > top_lvl) &&
                (!found || src_lvl >= win_lvl)) begin
                found   = 1'b1;
                win_idx = idx_t'(i);
                win_lvl = src_lvl;
            end
        end
    end
endmodule

// File: rtl/pair_prio_irq_ctrl.sv
module pair_prio_irq_ctrl
    import pic_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC-NUM_EXT-1:0] int_set,
    input  logic [NUM_EXT-1:0]         ext_pin,
    input  logic [NUM_EXT-1:0]         ext_level,
    input  logic                       sw_wr,
    input  logic [IDX_W-1:0]           sw_idx,
    input  logic                       sw_val,
    input  logic [NUM_SRC-1:0]         src_en,
    input  logic                       glob_en,
    input  logic [NUM_PAIR-1:0]        lvl_hi,
    input  logic [NUM_PAIR-1:0]        lvl_lo,
    input  logic                       ack,
    input  logic                       reti,
    output logic                       irq,
    output logic [IDX_W-1:0]           irq_idx,
    output logic [NUM_SRC-1:0]         pend,
    output logic [NUM_LVL-1:0]         in_service
);
    pic_state_t st_d, st_q;

    logic [NUM_EXT-1:0] ext_fall, ext_low;
    logic [NUM_SRC-1:0] hw_set, lvl_src, lvl_val, cand;
    logic               found, ack_take, reti_done, clr, v;
    idx_t               win_idx;
    lvl_t               win_lvl, ack_lvl;

    for (genvar e = 0; e < NUM_EXT; e++) begin : g_pin
        pic_pin_cond u_pin (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (ext_pin[e]),
            .fall (ext_fall[e]),
            .low  (ext_low[e])
        );
    end

    assign hw_set  = {int_set, ext_fall};
    assign lvl_src = {{(NUM_SRC-NUM_EXT){1'b0}}, ext_level};
    assign lvl_val = {{(NUM_SRC-NUM_EXT){1'b0}}, ext_low};
    assign cand    = st_q.flag & src_en & {NUM_SRC{glob_en}};

    pic_prio_sel u_sel (
        .cand   (cand),
        .lvl_hi (lvl_hi),
        .lvl_lo (lvl_lo),
        .isv    (st_q.isv),
        .found  (found),
        .win_idx(win_idx),
        .win_lvl(win_lvl)
    );

    assign ack_take = ack && st_q.irq;
    assign ack_lvl  = {lvl_hi[st_q.idx[IDX_W-1:1]], lvl_lo[st_q.idx[IDX_W-1:1]]};

    always_comb begin
        st_d      = st_q;
        reti_done = 1'b0;
        clr       = 1'b0;
        v         = 1'b0;
        // request flags
        for (int i = 0; i < NUM_SRC; i++) begin
            if (lvl_src[i]) begin
                st_d.flag[i] = lvl_val[i];
            end else begin
                clr = ack_take && (st_q.idx == idx_t'(i));
                v   = (st_q.flag[i] && !clr) || hw_set[i];
                if (sw_wr && sw_idx == idx_t'(i)) v = sw_val;
                st_d.flag[i] = v;
            end
        end
        // in-service bitmap: close the top level, then open the acked one
        if (reti) begin
            for (int l = NUM_LVL - 1; l >= 0; l--) begin
                if (!reti_done && st_q.isv[l]) begin
                    st_d.isv[l] = 1'b0;
                    reti_done   = 1'b1;
                end
            end
        end
        if (ack_take) st_d.isv[ack_lvl] = 1'b1;
        // request towards the processor
        if (ack_take) begin
            st_d.irq = 1'b0;
        end else if (!st_q.irq && found) begin
            st_d.irq = 1'b1;
            st_d.idx = win_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq        = st_q.irq;
    assign irq_idx    = st_q.idx;
    assign pend       = st_q.flag;
    assign in_service = st_q.isv;

    // R9: request and index hold until taken
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack) |=> (irq && $stable(irq_idx)));

    // R10: acknowledge opens the level of the taken source
    a_r10_ack_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && ack) |=> (!irq && in_service[$past(ack_lvl)]));

    // R8: nothing preempts the top level
    a_r8_top_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (in_service[NUM_LVL-1] && !irq) |=> !irq);

    // R6: global disable keeps the line low
    a_r6_global_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!glob_en && !irq) |=> !irq);

    // R11: return closes exactly one level
    a_r11_reti_one: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && (in_service != '0) && !(ack && irq)) |=>
        ($countones(in_service) == $countones($past(in_service)) - 1));

    // R7: index always names a real source
    a_r7_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_idx < IDX_W'(NUM_SRC)));
endmodule

// File: tb/pair_prio_irq_ctrl_test.sv
`timescale 1ns/1ps
module pair_prio_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [9:0]  int_set;
    logic [1:0]  ext_pin, ext_level;
    logic        sw_wr, sw_val;
    logic [3:0]  sw_idx;
    logic [11:0] src_en;
    logic        glob_en;
    logic [5:0]  lvl_hi, lvl_lo;
    logic        ack, reti;
    logic        irq;
    logic [3:0]  irq_idx;
    logic [11:0] pend;
    logic [3:0]  in_service;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    pair_prio_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .int_set(int_set), .ext_pin(ext_pin),
        .ext_level(ext_level), .sw_wr(sw_wr), .sw_idx(sw_idx), .sw_val(sw_val),
        .src_en(src_en), .glob_en(glob_en), .lvl_hi(lvl_hi), .lvl_lo(lvl_lo),
        .ack(ack), .reti(reti), .irq(irq), .irq_idx(irq_idx), .pend(pend),
        .in_service(in_service)
    );

    typedef struct packed {
        logic [11:0] mask;
        logic [5:0]  hi;
        logic [5:0]  lo;
        logic [11:0] en;
        logic        gen;
        logic        exp_irq;
        logic [3:0]  exp_idx;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{12'h020, 6'h00, 6'h00, 12'hFFF, 1'b1, 1'b1, 4'd5},
        '{12'h030, 6'h00, 6'h00, 12'hFFF, 1'b1, 1'b1, 4'd4},
        '{12'h208, 6'h00, 6'h00, 12'hFFF, 1'b1, 1'b1, 4'd3},
        '{12'h208, 6'h00, 6'h10, 12'hFFF, 1'b1, 1'b1, 4'd9},
        '{12'h208, 6'h02, 6'h10, 12'hFFF, 1'b1, 1'b1, 4'd3},
        '{12'h208, 6'h10, 6'h02, 12'hFFF, 1'b1, 1'b1, 4'd9},
        '{12'h208, 6'h12, 6'h02, 12'hFFF, 1'b1, 1'b1, 4'd3},
        '{12'h080, 6'h00, 6'h00, 12'hF7F, 1'b1, 1'b0, 4'd0},
        '{12'h480, 6'h00, 6'h00, 12'hF7F, 1'b1, 1'b1, 4'd10},
        '{12'h080, 6'h00, 6'h00, 12'hFFF, 1'b0, 1'b0, 4'd0},
        '{12'h804, 6'h20, 6'h20, 12'hFFF, 1'b1, 1'b1, 4'd11}
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic defaults();
        int_set = '0; ext_pin = 2'b11; ext_level = 2'b00;
        sw_wr = 0; sw_idx = '0; sw_val = 0;
        src_en = 12'hFFF; glob_en = 1; lvl_hi = '0; lvl_lo = '0;
        ack = 0; reti = 0;
    endtask

    task automatic do_reset();
        defaults();
        rst_n = 0;
        tick(2);
        rst_n = 1;
        tick(3);
    endtask

    task automatic sw_write(input int idx, input logic val);
        sw_wr = 1; sw_idx = 4'(idx); sw_val = val;
        tick(1);
        sw_wr = 0;
    endtask

    task automatic pulse_set(input int src);
        int_set = '0;
        int_set[src-2] = 1'b1;
        tick(1);
        int_set = '0;
    endtask

    initial begin
        #(200000 * 5);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        do_reset();

        // reset state (R10)
        chk("R10 reset irq", 32'(irq), 0);
        chk("R10 reset pend", 32'(pend), 0);
        chk("R10 reset in_service", 32'(in_service), 0);
        // R9: ack with irq low ignored
        ack = 1; tick(1); ack = 0;
        chk("R9 stray ack", 32'(in_service), 0);

        // vector table: R5 R6 R7 R1
        for (int k = 0; k < NV; k++) begin
            lvl_hi = VECS[k].hi; lvl_lo = VECS[k].lo;
            src_en = VECS[k].en; glob_en = VECS[k].gen;
            int_set = VECS[k].mask[11:2];
            tick(1);
            int_set = '0;
            chk($sformatf("R1 vec%0d pend", k), 32'(pend), 32'(VECS[k].mask));
            tick(1);
            chk($sformatf("R7 vec%0d irq", k), 32'(irq), 32'(VECS[k].exp_irq));
            if (VECS[k].exp_irq) begin
                chk($sformatf("R5 vec%0d idx", k), 32'(irq_idx), 32'(VECS[k].exp_idx));
                ack = 1; tick(1); ack = 0;
                chk($sformatf("R10 vec%0d in_service", k), 32'(in_service),
                    32'(4'b0001 << {VECS[k].hi[VECS[k].exp_idx/2], VECS[k].lo[VECS[k].exp_idx/2]}));
                chk($sformatf("R1 vec%0d ack clears", k), 32'(pend[VECS[k].exp_idx]), 0);
            end
            for (int s = 2; s < 12; s++) sw_write(s, 1'b0);
            reti = 1; tick(1); reti = 0;
            chk($sformatf("R11 vec%0d closed", k), 32'(in_service), 0);
            defaults();
            tick(1);
        end

        // R8 R11: upward nesting
        do_reset();
        pulse_set(2); tick(1);
        chk("R9 src2 raised", 32'({irq, irq_idx}), 32'({1'b1, 4'd2}));
        ack = 1; tick(1); ack = 0;
        chk("R10 level0 open", 32'(in_service), 32'h1);
        pulse_set(10); tick(1);
        chk("R8 same level waits", 32'(irq), 0);
        lvl_lo[5] = 1'b1; tick(1);
        chk("R8 higher level preempts", 32'({irq, irq_idx}), 32'({1'b1, 4'd10}));
        ack = 1; tick(1); ack = 0;
        chk("R10 nested", 32'(in_service), 32'h3);
        reti = 1; tick(1); reti = 0;
        chk("R11 top cleared", 32'(in_service), 32'h1);
        reti = 1; tick(1); reti = 0;
        chk("R11 all cleared", 32'(in_service), 32'h0);

        // R8: level 3 locks out everything
        do_reset();
        lvl_hi[2] = 1; lvl_lo[2] = 1;
        pulse_set(4); tick(1);
        chk("R8 lvl3 raised", 32'({irq, irq_idx}), 32'({1'b1, 4'd4}));
        ack = 1; tick(1); ack = 0;
        chk("R8 lvl3 open", 32'(in_service), 32'h8);
        lvl_hi[3] = 1; lvl_lo[3] = 1;
        pulse_set(6); tick(2);
        chk("R8 lvl3 not preempted", 32'(irq), 0);

        // R9: hold while a better request arrives
        do_reset();
        pulse_set(6); tick(1);
        chk("R9 src6 raised", 32'({irq, irq_idx}), 32'({1'b1, 4'd6}));
        lvl_hi[4] = 1; lvl_lo[4] = 1;
        pulse_set(8); tick(1);
        chk("R9 held idx", 32'({irq, irq_idx}), 32'({1'b1, 4'd6}));
        ack = 1; tick(1); ack = 0;
        chk("R10 irq drops on ack", 32'(irq), 0);
        tick(1);
        chk("R7 next winner", 32'({irq, irq_idx}), 32'({1'b1, 4'd8}));

        // R2: software writes
        do_reset();
        sw_write(7, 1'b1);
        chk("R2 sw set", 32'(pend[7]), 1);
        tick(1);
        chk("R2 sw raise", 32'({irq, irq_idx}), 32'({1'b1, 4'd7}));
        sw_write(7, 1'b0);
        chk("R2 sw cancel", 32'(pend[7]), 0);
        int_set[7] = 1'b1; sw_wr = 1; sw_idx = 4'd9; sw_val = 0;
        tick(1);
        int_set = '0; sw_wr = 0;
        chk("R2 sw beats hw", 32'(pend[9]), 0);

        // R3: falling edge on pin 0
        do_reset();
        ext_pin[0] = 1'b0;
        tick(2);
        chk("R3 not yet", 32'(pend[0]), 0);
        tick(1);
        chk("R3 edge sets", 32'(pend[0]), 1);
        tick(1);
        chk("R3 raise", 32'({irq, irq_idx}), 32'({1'b1, 4'd0}));
        ack = 1; tick(1); ack = 0;
        chk("R3 ack clears", 32'(pend[0]), 0);
        tick(3);
        chk("R3 held low no retrigger", 32'(pend[0]), 0);

        // R4: level mode on pin 1
        do_reset();
        ext_level = 2'b10;
        tick(1);
        sw_write(1, 1'b1);
        chk("R4 sw write ignored", 32'(pend[1]), 0);
        ext_pin[1] = 1'b0;
        tick(3);
        chk("R4 follows low pin", 32'(pend[1]), 1);
        sw_write(1, 1'b0);
        chk("R4 sw clear ignored", 32'(pend[1]), 1);
        ext_pin[1] = 1'b1;
        tick(3);
        chk("R4 follows high pin", 32'(pend[1]), 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule